// File: doc/BRIEF.md
# Two-Requester Sticky Bus Arbiter

This block decides which of two buses may drive a shared path. Each bus raises a request line. The block answers with two enable lines that open that bus's buffers. It is a three-state Moore machine with the states idle, A granted and B granted. Both enables decode from the registered state alone, so an enable changes only at a clock edge.

When the machine leaves idle, A wins a tie. Once a grant is held it is sticky. It passes to the other bus only when the holder drops its request while the other bus requests. When both lines are low, any grant is released. The state uses a fixed two-bit code: idle is 00, A is 01 and B is 11. The unused code 10 returns to idle on the next clock.

Top module: `arb2_moore`

## Requirements
- R1: While `rst_n` is low, the machine is idle and both grants are 0 (grant_a, grant_b = 0, 0).
- R2: With req_a, req_b = 0, 0 at a clock edge, the machine is idle after that edge and both grants are 0, whatever the prior state.
- R3: From idle, a clock edge with req_a = 1 (and req_b either value) moves to state A, giving grant_a, grant_b = 1, 0.
- R4: From idle, a clock edge with req_a, req_b = 0, 1 moves to state B, giving grant_a, grant_b = 0, 1.
- R5: In state A, req_a, req_b = 1, 0 or 1, 1 holds A. Only 0, 1 moves the machine to B.
- R6: In state B, req_a, req_b = 0, 1 or 1, 1 holds B. Only 1, 0 moves the machine to A.
- R7: At most one grant is high at any time. The grants are a function of the state code only: 00 gives no grant, 01 gives grant_a, 11 gives grant_b. The unused code 10 gives no grant and goes to idle at the next edge.
- R8: A change on the request inputs between clock edges leaves the grants unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_a | input | 1 | Request from bus A |
| req_b | input | 1 | Request from bus B |
| grant_a | output | 1 | Enables the bus A buffers |
| grant_b | output | 1 | Enables the bus B buffers |

## Verification
The block has no tunable parameters, so the bench builds it as it is. It drives every sequence of three request patterns from reset, which is 64 sequences. This reaches every state and input pair, including a hold, a hand-over and a release from each grant state. In each step the bench also changes the inputs before the edge to confirm the grants wait for the clock. The unused code cannot be reached from the ports, so only the bound checker covers its recovery.

// File: rtl/arb2_pkg.sv
package arb2_pkg;
  localparam int STATE_W = 2;
  typedef logic [STATE_W-1:0] arb_state_t;
  // Fixed codes; 2'b10 is unused and recovers to idle.
  localparam arb_state_t ST_IDLE   = 2'b00;
  localparam arb_state_t ST_A      = 2'b01;
  localparam arb_state_t ST_B      = 2'b11;
  localparam arb_state_t ST_UNUSED = 2'b10;
endpackage

// File: rtl/arb2_next.sv
module arb2_next
  import arb2_pkg::*;
(
  input  arb_state_t cur_state,
  input  logic       req_a,
  input  logic       req_b,
  output arb_state_t nxt_state
);
  always_comb begin
    nxt_state = ST_IDLE;
    unique case (cur_state)
      ST_IDLE: begin
        if (req_a)      nxt_state = ST_A;
        else if (req_b) nxt_state = ST_B;
        else            nxt_state = ST_IDLE;
      end
      ST_A: begin
        if (!req_a && !req_b) nxt_state = ST_IDLE;
        else if (!req_a)      nxt_state = ST_B;
        else                  nxt_state = ST_A;
      end
      ST_B: begin
        if (!req_a && !req_b) nxt_state = ST_IDLE;
        else if (!req_b)      nxt_state = ST_A;
        else                  nxt_state = ST_B;
      end
      default: nxt_state = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/arb2_state_reg.sv
module arb2_state_reg
  import arb2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  arb_state_t nxt_state,
  output arb_state_t cur_state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_state <= ST_IDLE;
    else        cur_state <= nxt_state;
  end
endmodule

// File: rtl/arb2_out_dec.sv
module arb2_out_dec
  import arb2_pkg::*;
(
  input  arb_state_t cur_state,
  output logic       grant_a,
  output logic       grant_b
);
  always_comb begin
    grant_a = (cur_state == ST_A);
    grant_b = (cur_state == ST_B);
  end
endmodule

// File: rtl/arb2_moore.sv
module arb2_moore
  import arb2_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_a,
  input  logic req_b,
  output logic grant_a,
  output logic grant_b
);
  arb_state_t state_q;
  arb_state_t state_d;

  arb2_next u_next (
    .cur_state (state_q),
    .req_a     (req_a),
    .req_b     (req_b),
    .nxt_state (state_d)
  );

  arb2_state_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_state (state_d),
    .cur_state (state_q)
  );

  arb2_out_dec u_dec (
    .cur_state (state_q),
    .grant_a   (grant_a),
    .grant_b   (grant_b)
  );
endmodule

// File: rtl/arb2_moore_chk.sv
module arb2_moore_chk
  import arb2_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_a,
  input logic       req_b,
  input logic       grant_a,
  input logic       grant_b,
  input arb_state_t state_q
);
  always @(posedge clk) begin
    if (!rst_n)
      assert_reset_idle_R1: assert (state_q == ST_IDLE && !grant_a && !grant_b);
  end

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_a && !req_b) |=> (state_q == ST_IDLE));

  assert_idle_to_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && req_a) |=> grant_a);

  assert_idle_to_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !req_a && req_b) |=> grant_b);

  assert_a_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_A && req_a) |=> grant_a);

  assert_a_handover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_A && !req_a && req_b) |=> grant_b);

  assert_b_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_B && req_b) |=> grant_b);

  assert_b_handover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_B && req_a && !req_b) |=> grant_a);

  assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_a, grant_b}));

  assert_unused_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UNUSED) |=> (state_q == ST_IDLE));
endmodule

bind arb2_moore arb2_moore_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_a   (req_a),
  .req_b   (req_b),
  .grant_a (grant_a),
  .grant_b (grant_b),
  .state_q (state_q)
);

// File: tb/arb2_moore_bench.sv
module arb2_moore_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_a = 1'b0;
  logic req_b = 1'b0;
  logic grant_a, grant_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arb2_moore u_arb2_moore (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_a   (req_a),
    .req_b   (req_b),
    .grant_a (grant_a),
    .grant_b (grant_b)
  );

  // Bench model: 0 idle, 1 A, 2 B
  function automatic int model_next(int s, bit a, bit b);
    if (!a && !b) return 0;
    case (s)
      0: return a ? 1 : 2;
      1: return a ? 1 : 2;
      default: return b ? 2 : 1;
    endcase
  endfunction

  function automatic string req_tag(int s, bit a, bit b);
    if (!a && !b) return "R2";
    case (s)
      0: return a ? "R3" : "R4";
      1: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_grants(int s, string tag);
    bit ea = (s == 1);
    bit eb = (s == 2);
    checks++;
    if (grant_a !== ea || grant_b !== eb) begin
      fails++;
      $display("FAIL %s: grants got %b%b expected %b%b", tag, grant_a, grant_b, ea, eb);
    end
    checks++;
    if (grant_a && grant_b) begin
      fails++;
      $display("FAIL R7: both grants high got 11 expected at most one");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run hung got timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int seq = 0; seq < 64; seq++) begin
      int st;
      @(negedge clk);
      rst_n = 1'b0;
      req_a = 1'b1;
      req_b = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check_grants(0, "R1");
      rst_n = 1'b1;
      st = 0;
      for (int step = 0; step < 3; step++) begin
        bit a = seq[2*step+1];
        bit b = seq[2*step];
        req_a = a;
        req_b = b;
        #1;
        check_grants(st, "R8");
        @(posedge clk);
        st = model_next(st, a, b);
        @(negedge clk);
        check_grants(st, req_tag(st == model_next(st, a, b) ? st : st, a, b));
      end
    end
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule